// File: doc/BRIEF.md
# Comma-based word aligner

This block sits after a deserializer that delivers 10-bit words with no known character boundary. On every clock it looks at the last two words it received, which makes a 20-bit view of the stream, and checks all ten bit offsets against up to two programmed 10-bit comma patterns. When a comma shows up at an offset the block is not already using, the block moves its output slice to that offset. The comma then arrives on the output as one whole character, and a realignment pulse is raised.

A comma that arrives at the offset already in use raises the comma indication but leaves the alignment as it is. A global enable turns detection off. While detection is off the block keeps slicing the stream at the last offset it chose. Each pattern slot has its own enable, so the block can match one pattern or two.

Top module: `word_aligner`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `offset_o` is 0 and `aligned_o`, `comma_o`, `realign_o` and `dout_o` are all 0.
- R2: While `det_en_i` is 0, no comma is reported and `offset_o` does not change, even when a pattern is present in the stream.
- R3: Pattern slot 0 is `pat_i[9:0]` and slot 1 is `pat_i[19:10]`. Slot n takes part in matching only while `pat_en_i[n]` is 1, and either enabled slot can trigger detection.
- R4: Stream bits enter MSB first, so `din_i[9]` is the earliest bit. Take a comma whose first bit is bit (9-k) of word j, for k from 0 to 9. Two rising edges after the edge that samples word j, `comma_o` is 1, `offset_o` is k and `dout_o` equals the comma.
- R5: A comma found at an offset different from the current one updates `offset_o` and raises `realign_o`. `realign_o` lasts one cycle unless the next cycle also needs a new offset.
- R6: A comma found at the current offset while `aligned_o` is 1 gives `realign_o` = 0 and leaves `offset_o` unchanged.
- R7: After reset the block is unaligned. The first comma it detects always raises `realign_o`, even at offset 0, and sets `aligned_o` to 1.
- R8: When comma matches exist at several offsets in the same cycle, the lowest offset is taken, whichever slot matched.
- R9: Each output word is the 10 stream bits that start k bits into the input word two edges earlier, where k is the offset in force. Latency is fixed at two edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| det_en_i | input | 1 | Comma detection enable |
| pat_i | input | 20 | Two 10-bit comma patterns; slot 0 in the low bits |
| pat_en_i | input | 2 | Per-slot pattern enable |
| din_i | input | 10 | Unaligned input word, bit 9 first on the wire |
| dout_o | output | 10 | Aligned output word |
| comma_o | output | 1 | A comma was found and the output is aligned to it |
| realign_o | output | 1 | One-cycle pulse when the offset changed or first alignment occurred |
| aligned_o | output | 1 | Set once a comma has been seen since reset |
| offset_o | output | 4 | Current bit offset, 0 to 9 |

## Verification
The bench builds the block with its default parameters: a 10-bit word and two pattern slots. With these values every one of the ten offsets can be checked, and both slots can be made to match within one 20-bit view. This is how the lowest-offset rule is tested with either slot winning. The filler between commas is an alternating bit stream. Neither test pattern can occur inside it, so any comma report has to come from the pattern the bench inserted, at the position it chose.

// File: rtl/wa_pkg.sv
package wa_pkg;
  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_LOCK = 1'b1
  } align_st_e;
endpackage

// File: rtl/wa_window.sv
module wa_window #(
  parameter int W = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [W-1:0]   din_i,
  output logic [2*W-1:0] win_o
);
  logic [W-1:0] cur_q, prev_q;
  logic [W-1:0] cur_d, prev_d;

  always_comb begin
    cur_d  = din_i;
    prev_d = cur_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      cur_q  <= cur_d;
      prev_q <= prev_d;
    end
  end

  // older word in the upper half: window bit 2W-1 is the earliest bit
  assign win_o = {prev_q, cur_q};
endmodule

// File: rtl/wa_match.sv
module wa_match #(
  parameter int W    = 10,
  parameter int NPAT = 2
) (
  input  logic [2*W-1:0]    win_i,
  input  logic [NPAT*W-1:0] pat_i,
  input  logic [NPAT-1:0]   pat_en_i,
  output logic [W-1:0]      hit_o
);
  for (genvar k = 0; k < W; k++) begin : g_off
    logic [W-1:0]    slice;
    logic [NPAT-1:0] eq;
    assign slice = win_i[2*W-1-k -: W];
    for (genvar p = 0; p < NPAT; p++) begin : g_pat
      assign eq[p] = pat_en_i[p] && (slice == pat_i[p*W +: W]);
    end
    assign hit_o[k] = |eq;
  end
endmodule

// File: rtl/wa_pick.sv
module wa_pick #(
  parameter int W = 10,
  localparam int OFFW = $clog2(W)
) (
  input  logic [W-1:0]    hit_i,
  output logic            found_o,
  output logic [OFFW-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    // scan downward so the lowest set offset is written last
    for (int k = W - 1; k >= 0; k--) begin
      if (hit_i[k]) begin
        found_o = 1'b1;
        idx_o   = OFFW'(k);
      end
    end
  end
endmodule

// File: rtl/word_aligner.sv
module word_aligner #(
  parameter int W    = 10,
  parameter int NPAT = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  det_en_i,
  input  logic [NPAT*W-1:0]     pat_i,
  input  logic [NPAT-1:0]       pat_en_i,
  input  logic [W-1:0]          din_i,
  output logic [W-1:0]          dout_o,
  output logic                  comma_o,
  output logic                  realign_o,
  output logic                  aligned_o,
  output logic [$clog2(W)-1:0]  offset_o
);
  import wa_pkg::*;
  localparam int OFFW = $clog2(W);

  logic [2*W-1:0] win;
  logic [W-1:0]   hit;
  logic           found;
  logic [OFFW-1:0] idx;

  wa_window #(.W(W)) u_window (
    .clk(clk), .rst_n(rst_n), .din_i(din_i), .win_o(win)
  );

  wa_match #(.W(W), .NPAT(NPAT)) u_match (
    .win_i(win), .pat_i(pat_i), .pat_en_i(pat_en_i), .hit_o(hit)
  );

  wa_pick #(.W(W)) u_pick (
    .hit_i(hit), .found_o(found), .idx_o(idx)
  );

  align_st_e       st_q, st_d;
  logic [OFFW-1:0] off_q, off_d;
  logic [W-1:0]    dout_q, dout_d;
  logic            comma_q, comma_d;
  logic            realign_q, realign_d;
  logic            take;
  logic            move;
  logic [2*W-1:0]  shifted;

  always_comb begin
    take      = det_en_i && found;
    move      = take && ((st_q == ST_HUNT) || (idx != off_q));
    off_d     = move ? idx : off_q;
    st_d      = take ? ST_LOCK : st_q;
    shifted   = win << off_d;
    dout_d    = shifted[2*W-1 -: W];
    comma_d   = take;
    realign_d = move;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_HUNT;
      off_q     <= '0;
      dout_q    <= '0;
      comma_q   <= 1'b0;
      realign_q <= 1'b0;
    end else begin
      st_q      <= st_d;
      off_q     <= off_d;
      dout_q    <= dout_d;
      comma_q   <= comma_d;
      realign_q <= realign_d;
    end
  end

  assign dout_o    = dout_q;
  assign comma_o   = comma_q;
  assign realign_o = realign_q;
  assign aligned_o = (st_q == ST_LOCK);
  assign offset_o  = off_q;

  assert_comma_needs_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    comma_o |-> $past(det_en_i));
  assert_offset_frozen_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(det_en_i) |-> $stable(offset_o));
  assert_realign_has_comma_R5: assert property (@(posedge clk) disable iff (!rst_n)
    realign_o |-> comma_o);
  assert_offset_moves_on_realign_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(offset_o) |-> realign_o);
  assert_locked_realign_moves_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (realign_o && $past(aligned_o)) |-> !$stable(offset_o));
  assert_comma_sets_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    comma_o |-> aligned_o);
endmodule

// File: tb/word_aligner_bench.sv
`timescale 1ns/1ps
module word_aligner_bench;
  localparam logic [9:0] PA = 10'b0011111010;
  localparam logic [9:0] PB = 10'b1100000101;

  typedef struct packed {
    logic [3:0] k;
    logic       use_b;
    logic       exp_re;
  } vec_t;

  localparam vec_t VT [6] = '{
    '{k: 4'd3, use_b: 1'b0, exp_re: 1'b1},
    '{k: 4'd3, use_b: 1'b1, exp_re: 1'b0},
    '{k: 4'd7, use_b: 1'b0, exp_re: 1'b1},
    '{k: 4'd0, use_b: 1'b1, exp_re: 1'b1},
    '{k: 4'd9, use_b: 1'b0, exp_re: 1'b1},
    '{k: 4'd9, use_b: 1'b0, exp_re: 1'b0}
  };

  logic        clk, rst_n, det_en;
  logic [19:0] pat;
  logic [1:0]  pat_en;
  logic [9:0]  din, dout;
  logic        comma, realign, aligned;
  logic [3:0]  offset;

  word_aligner u_word_aligner (
    .clk(clk), .rst_n(rst_n), .det_en_i(det_en), .pat_i(pat), .pat_en_i(pat_en),
    .din_i(din), .dout_o(dout), .comma_o(comma), .realign_o(realign),
    .aligned_o(aligned), .offset_o(offset)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int errs = 0;
  int nchk = 0;
  logic [9:0] od [6];
  logic       oc [6], orl [6], oal [6];
  logic [3:0] oo [6];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [0:59] mk(input logic [9:0] p, input int pos, input logic ins);
    logic [0:59] r;
    for (int b = 0; b < 60; b++) r[b] = b[0];
    if (ins) r[pos +: 10] = p;
    return r;
  endfunction

  task automatic run(input logic [0:59] s);
    for (int i = 0; i < 6; i++) begin
      din = s[i*10 +: 10];
      @(posedge clk); #2;
      od[i] = dout; oc[i] = comma; orl[i] = realign; oal[i] = aligned; oo[i] = offset;
    end
  endtask

  initial begin
    #2000000;
    errs++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end

  initial begin
    logic [0:59] s;
    logic [9:0]  p, piece;
    rst_n = 1'b0; det_en = 1'b1; pat = {PB, PA}; pat_en = 2'b11; din = '0;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 offset in reset", offset, 0);
    chk("R1 aligned in reset", aligned, 0);
    chk("R1 outputs in reset", {comma, realign, dout}, 0);
    rst_n = 1'b1;
    @(posedge clk); #2;
    chk("R1 after release", {aligned, comma, realign, offset}, 0);

    // R9: offset 0, no comma, words pass with two-edge latency
    s = mk(PA, 0, 1'b0);
    run(s);
    chk("R9 word0 latency", od[2], s[0 +: 10]);
    chk("R9 word3 latency", od[5], s[30 +: 10]);
    chk("R7 unaligned before comma", oal[5], 0);

    // R7: first comma at offset 0 still realigns
    s = mk(PA, 20, 1'b1);
    run(s);
    chk("R7 realign at offset 0", orl[4], 1);
    chk("R7 aligned set", oal[4], 1);
    chk("R4 comma at offset 0", od[4], PA);

    // R2: detection disabled
    det_en = 1'b0;
    s = mk(PA, 25, 1'b1);
    run(s);
    chk("R2 no comma when disabled", oc[4], 0);
    chk("R2 offset frozen", oo[4], 0);
    chk("R2 data at old offset", od[4], s[20 +: 10]);
    det_en = 1'b1;

    // R3: disabled slot ignored
    pat_en = 2'b01;
    s = mk(PB, 24, 1'b1);
    run(s);
    chk("R3 disabled slot no comma", oc[4], 0);
    chk("R3 disabled slot offset", oo[4], 0);
    pat_en = 2'b11;

    // table walk: R3 R4 R5 R6 R9
    foreach (VT[r]) begin
      p = VT[r].use_b ? PB : PA;
      s = mk(p, 20 + int'(VT[r].k), 1'b1);
      run(s);
      chk("R4 comma flag", oc[4], 1);
      chk("R4 aligned data", od[4], p);
      chk("R4 offset", oo[4], VT[r].k);
      chk("R5/R6 realign", orl[4], VT[r].exp_re);
      chk("R5 pulse width", orl[5], 0);
      chk("R9 next word", od[5], s[30 + int'(VT[r].k) +: 10]);
      if (VT[r].use_b) chk("R3 slot1 match", oc[4], 1);
    end

    // R8: two offsets in one view, lowest wins (slot0 lower)
    s = mk(PA, 23, 1'b1);
    piece = s[25 +: 10];
    pat = {piece, PA};
    run(s);
    chk("R8 lowest offset slot0", oo[4], 3);
    chk("R8 data slot0", od[4], PA);
    // slot1 at lower offset
    s = mk(PA, 21, 1'b1);
    piece = s[23 +: 10];
    pat = {PA, piece};
    run(s);
    chk("R8 lowest offset slot1", oo[4], 1);
    chk("R8 data slot1", od[4], PA);
    chk("R8 realign", orl[4], 1);
    pat = {PB, PA};

    // R1: reset mid-stream
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    chk("R1 mid reset offset", offset, 0);
    chk("R1 mid reset aligned", aligned, 0);
    @(posedge clk); #2;
    rst_n = 1'b1;

    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end
endmodule